// File: doc/BRIEF.md
# Address-Triggered Glitch-Free CPU Clock Switch

This block produces the clock of a fully static CPU from two sources: a fast clock and a slower clock that paces an older base system. The fast clock is a whole multiple of the slow one, and their edges line up. When the CPU opens a bus cycle whose address falls inside a configurable legacy window, the block moves the CPU onto the slow clock. When that cycle has finished, it moves the CPU back to the fast clock. Outside the window the CPU runs at full speed. Every access into the older chipset therefore runs at the chipset's own pace, and no per-access wait-state logic is needed.

Each source has its own enable. The enable is synchronised in that source's clock domain, and its last stage updates on the falling edge. An enable switches on only after the other source's enable has been seen off. The output is therefore held low across a switch and never shows a shortened phase. After reset the CPU runs slow until its first access outside the window. The legacy window is set by a base value and a mask.

Top module: `addr_clk_switch`

## Requirements
- R1: Within 32 fast-clock cycles of reset release, the output runs from the slow clock and `slow_active` is 1.
- R2: An address-strobe assertion (`as_n` falling) whose address fails the window test puts the output on the fast clock within 32 fast cycles.
- R3: An address-strobe assertion with `(addr & WIN_MASK) == (WIN_BASE & WIN_MASK)` puts the output on the slow clock within 32 fast cycles. Address bits that are zero in the mask are ignored. With the defaults (base 0x00000, mask 0xC0000), 0x18000 and 0x3FFFF hit, and 0x40000 and 0xC1234 miss.
- R4: After a legacy access, the output returns to the fast clock only once `cyc_end` has pulsed during that access and `as_n` is high. With `as_n` high but no `cyc_end` pulse, the output stays slow.
- R5: No high or low phase of `clk_cpu` is shorter than half a fast-clock period while reset is inactive.
- R6: Once a selection has been stable for 32 fast cycles, `clk_cpu` equals the selected source clock, and the two source enables are never on together.
- R7: Once settled, `slow_active` is 1 exactly when the slow clock drives the output.
- R8: A legacy access made while the reset-time slow selection is still in force leaves the output slow after that access ends.
- R9: A `cyc_end` pulse outside a legacy access has no effect: the output stays on the fast clock.
- R10: While `rst_n` is low, `clk_cpu` is held low and `slow_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock |
| clk_slow | input | 1 | Slow source clock, edges aligned to clk_fast |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | CPU address bus, stable while as_n is low |
| as_n | input | 1 | Active-low address strobe |
| cyc_end | input | 1 | Pulse marking the end of the current bus cycle |
| clk_cpu | output | 1 | Gated CPU clock |
| slow_active | output | 1 | 1 while the slow clock drives clk_cpu |

## Verification
The hardest situation to reach is the reverse handover. A legacy access must first take the output slow, then stay slow while the strobe is already released but no end pulse has arrived, and only then go fast. The stimulus builds this with an access that raises `as_n` long before sending `cyc_end`. The bench also runs legacy accesses while the reset-time slow selection is still in force. A phase monitor times every edge of `clk_cpu` across each of these switches, so any truncated pulse at a handover is caught.

// File: rtl/cks_pkg.sv
package cks_pkg;
  // index of each clock source in the enable vector
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } clk_src_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/cks_req.sv
// Request logic in the fast domain: decides which source the CPU wants.
module cks_req #(
  parameter int              ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [ADDR_W-1:0] WIN_MASK = '1,
  parameter int              SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              cyc_end,
  output logic              want_slow
);
  logic [SYNC_N-1:0] rs_q, rs_nxt;
  logic [SYNC_N-1:0] as_q, as_nxt;
  logic [SYNC_N-1:0] ce_q, ce_nxt;
  logic              rst_int, as_s, ce_s;
  logic              as_prev_q, boot_q, hold_q, seen_q;
  logic              boot_d, hold_d, seen_d, want_d;
  logic              start, hit;

  // synchroniser chains: next state
  always_comb begin
    rs_nxt[0] = 1'b1;
    as_nxt[0] = as_n;
    ce_nxt[0] = cyc_end;
    for (int i = 1; i < SYNC_N; i++) begin
      rs_nxt[i] = rs_q[i-1];
      as_nxt[i] = as_q[i-1];
      ce_nxt[i] = ce_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_nxt;
  end

  assign rst_int = rs_q[SYNC_N-1];
  assign as_s    = as_q[SYNC_N-1];
  assign ce_s    = ce_q[SYNC_N-1];

  // selection state: next state
  always_comb begin
    start  = as_prev_q & ~as_s;
    hit    = ((addr & WIN_MASK) == (WIN_BASE & WIN_MASK));
    boot_d = boot_q;
    hold_d = hold_q;
    seen_d = seen_q;
    if (start) begin
      if (hit) hold_d = 1'b1;
      else     boot_d = 1'b0;
    end
    if (hold_q && ce_s) seen_d = 1'b1;
    if (seen_q && as_s) begin
      hold_d = 1'b0;
      seen_d = 1'b0;
    end
    want_d = boot_d | hold_d;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      as_q      <= '1;
      ce_q      <= '0;
      as_prev_q <= 1'b1;
      boot_q    <= 1'b1;
      hold_q    <= 1'b0;
      seen_q    <= 1'b0;
      want_slow <= 1'b1;
    end else begin
      as_q      <= as_nxt;
      ce_q      <= ce_nxt;
      as_prev_q <= as_s;
      boot_q    <= boot_d;
      hold_q    <= hold_d;
      seen_q    <= seen_d;
      want_slow <= want_d;
    end
  end
endmodule

// File: rtl/cks_en_stage.sv
// Per-source enable: synchronised in its own clock, last stage on falling edge.
module cks_en_stage #(
  parameter int SYNC_N = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  input  logic other_en,
  output logic en
);
  logic [SYNC_N-1:0] rs_q, rs_nxt;
  logic [SYNC_N-2:0] s_q, s_nxt;
  logic              rst_int;

  always_comb begin
    rs_nxt[0] = 1'b1;
    for (int i = 1; i < SYNC_N; i++) rs_nxt[i] = rs_q[i-1];
    s_nxt[0] = want & ~other_en;
    for (int i = 1; i < SYNC_N - 1; i++) s_nxt[i] = s_q[i-1];
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_nxt;
  end

  assign rst_int = rs_q[SYNC_N-1];

  always_ff @(posedge clk_src or negedge rst_int) begin
    if (!rst_int) s_q <= '0;
    else          s_q <= s_nxt;
  end

  // enable moves only while this source is low
  always_ff @(negedge clk_src or negedge rst_int) begin
    if (!rst_int) en <= 1'b0;
    else          en <= s_q[SYNC_N-2];
  end
endmodule

// File: rtl/addr_clk_switch.sv
// Top: address-decoded, glitch-free choice between fast and slow CPU clock.
module addr_clk_switch
  import cks_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'h00000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 20'hC0000,
  parameter int                SYNC_N   = 2
) (
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              cyc_end,
  output logic              clk_cpu,
  output logic              slow_active
);
  logic                 want_slow;
  logic [NUM_SRC-1:0]   src_clk, src_want, src_en;
  logic                 en_fast, en_slow;

  cks_req #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_MASK(WIN_MASK),
    .SYNC_N  (SYNC_N)
  ) req_i (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .addr     (addr),
    .as_n     (as_n),
    .cyc_end  (cyc_end),
    .want_slow(want_slow)
  );

  assign src_clk[SRC_FAST]  = clk_fast;
  assign src_clk[SRC_SLOW]  = clk_slow;
  assign src_want[SRC_FAST] = ~want_slow;
  assign src_want[SRC_SLOW] = want_slow;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    cks_en_stage #(.SYNC_N(SYNC_N)) stage_i (
      .clk_src (src_clk[g]),
      .rst_n   (rst_n),
      .want    (src_want[g]),
      .other_en(src_en[NUM_SRC-1-g]),
      .en      (src_en[g])
    );
  end

  assign en_fast     = src_en[SRC_FAST];
  assign en_slow     = src_en[SRC_SLOW];
  assign clk_cpu     = (clk_fast & en_fast) | (clk_slow & en_slow);
  assign slow_active = en_slow;
endmodule

// File: rtl/cks_chk.sv
// Properties of the switch, attached to the top by bind.
module cks_chk (
  input logic clk_fast,
  input logic rst_n,
  input logic en_fast,
  input logic en_slow
);
  // R6: never both sources at once
  assert_one_src_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(en_fast && en_slow));

  // R5: slow enable rises only after fast enable was already off
  assert_fast_off_first_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(en_slow) |-> $past(!en_fast));

  // R5: fast enable rises only after slow enable was already off
  assert_slow_off_first_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(en_fast) |-> $past(!en_slow));

  // R10: reset holds both enables off
  assert_rst_quiet_R10: assert property (@(posedge clk_fast)
    !rst_n |-> (!en_fast && !en_slow));
endmodule

bind addr_clk_switch cks_chk chk_i (
  .clk_fast(clk_fast),
  .rst_n   (rst_n),
  .en_fast (en_fast),
  .en_slow (en_slow)
);

// File: tb/addr_clk_switch_tb_top.sv
`timescale 1ns/1ps
module addr_clk_switch_tb_top;
  localparam int SETTLE = 32;
  localparam logic [19:0] BASE = 20'h00000;
  localparam logic [19:0] MASK = 20'hC0000;

  logic        clk_fast = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst_n    = 1'b0;
  logic [19:0] addr     = '0;
  logic        as_n     = 1'b1;
  logic        cyc_end  = 1'b0;
  logic        clk_cpu, slow_active;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  m_boot = 1, m_hold = 0, m_seen = 0;
  bit  m_last = 1;
  int  stable_cnt = 0;
  bit  mon_phase = 0;
  bit  finished = 0;
  real last_t = -1.0;

  always #2.5 clk_fast = ~clk_fast;   // 200 MHz
  always #10  clk_slow = ~clk_slow;   // one quarter, aligned edges

  addr_clk_switch dut_i (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .addr(addr), .as_n(as_n), .cyc_end(cyc_end),
    .clk_cpu(clk_cpu), .slow_active(slow_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [19:0] a);
    return (a & MASK) == (BASE & MASK);
  endfunction

  // reference model: desired source tracked and settled per fast cycle
  always @(posedge clk_fast) begin
    bit want;
    want = m_boot | m_hold;
    if (!rst_n || want != m_last) stable_cnt = 0;
    else stable_cnt++;
    m_last = want;
    #1;
    if (rst_n && stable_cnt >= SETTLE) begin
      chk(slow_active == want, "R7", slow_active, want);
      chk(clk_cpu == (want ? clk_slow : clk_fast), "R6", clk_cpu, want ? clk_slow : clk_fast);
    end
  end

  always @(negedge clk_fast) begin
    #1;
    if (rst_n && stable_cnt >= SETTLE)
      chk(clk_cpu == (m_last ? clk_slow : clk_fast), "R6", clk_cpu, m_last ? clk_slow : clk_fast);
  end

  // R5: every phase of the output at least half a fast period
  always @(clk_cpu) begin
    real t;
    t = $realtime;
    if (mon_phase && last_t >= 0.0) begin
      n_checks++;
      if (t - last_t < 2.49) begin
        n_errors++;
        $display("FAIL R5 at %0t: actual phase %0f ns expected >= 2.5 ns", $time, t - last_t);
      end
    end
    if (mon_phase) last_t = t;
  end

  task automatic wait_fast(input int n);
    repeat (n) @(negedge clk_fast);
  endtask

  task automatic do_reset();
    @(negedge clk_fast);
    mon_phase = 0;
    last_t    = -1.0;
    rst_n     = 1'b0;
    m_boot = 1; m_hold = 0; m_seen = 0;
    wait_fast(10);
    #1;
    chk(clk_cpu == 1'b0, "R10", clk_cpu, 0);
    chk(slow_active == 1'b0, "R10", slow_active, 0);
    wait_fast(3);
    #1;
    chk(clk_cpu == 1'b0, "R10", clk_cpu, 0);
    @(negedge clk_fast);
    rst_n     = 1'b1;
    mon_phase = 1;
    wait_fast(48);
    chk(slow_active == 1'b1, "R1", slow_active, 1);
  endtask

  task automatic m_strobe(input logic [19:0] a);
    if (in_win(a)) m_hold = 1; else m_boot = 0;
  endtask

  task automatic pulse_end();
    @(negedge clk_fast);
    cyc_end = 1'b1;
    if (m_hold) m_seen = 1;
    if (m_seen && as_n) begin m_hold = 0; m_seen = 0; end
    wait_fast(4);
    cyc_end = 1'b0;
  endtask

  // access with end pulse first (normal) or strobe released first (late end)
  task automatic access(input logic [19:0] a, input bit late_end, input string req, input bit exp_mid);
    @(negedge clk_fast);
    addr = a;
    as_n = 1'b0;
    m_strobe(a);
    wait_fast(48);
    chk(slow_active == exp_mid, req, slow_active, exp_mid);
    if (!late_end) begin
      pulse_end();
      wait_fast(4);
      as_n = 1'b1;
      if (m_seen) begin m_hold = 0; m_seen = 0; end
    end else begin
      as_n = 1'b1;
      wait_fast(48);
      chk(slow_active == 1'b1, "R4", slow_active, 1);
      pulse_end();
    end
    wait_fast(48);
  endtask

  initial begin
    wait_fast(8);
    #1;
    chk(clk_cpu == 1'b0, "R10", clk_cpu, 0);
    chk(slow_active == 1'b0, "R10", slow_active, 0);
    @(negedge clk_fast);
    rst_n     = 1'b1;
    mon_phase = 1;
    wait_fast(48);
    chk(slow_active == 1'b1, "R1", slow_active, 1);

    // R8: legacy access during reset-time slow mode keeps slow
    access(20'h12345, 1'b0, "R8", 1'b1);
    chk(slow_active == 1'b1, "R8", slow_active, 1);

    // R2: first access outside the window goes fast
    access(20'h40000, 1'b0, "R2", 1'b0);
    chk(slow_active == 1'b0, "R2", slow_active, 0);

    // R9: stray end pulse while fast has no effect
    pulse_end();
    wait_fast(48);
    chk(slow_active == 1'b0, "R9", slow_active, 0);
    chk(m_boot == 0 && m_hold == 0, "R9", m_hold, 0);

    // R3 then R4 return to fast
    access(20'h18000, 1'b0, "R3", 1'b1);
    chk(slow_active == 1'b0, "R4", slow_active, 0);

    // R3 masked-out bits ignored; R4 late end pulse
    access(20'h3FFFF, 1'b1, "R3", 1'b1);
    chk(slow_active == 1'b0, "R4", slow_active, 0);

    // R2: other miss
    access(20'hC1234, 1'b0, "R2", 1'b0);
    chk(slow_active == 1'b0, "R2", slow_active, 0);

    // R10 and R1: reset mid-run from fast mode
    do_reset();
    access(20'h3FFFF, 1'b0, "R8", 1'b1);
    access(20'h80000, 1'b0, "R2", 1'b0);
    access(20'h00001, 1'b1, "R3", 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog at %0t: actual running expected done", $time);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule